// File: doc/BRIEF.md
# Single-wire debug entry sequencer

This block owns the mode of a one-wire debug port whose line is open-drain and pulled high. After power-up it sits in an idle state and watches the line, sampling it on a slow-clock strobe. A host wakes the port by sending a train of eight pulses. The first four have a long period and the last four have a period about half as long. The block measures every period in slow-clock ticks. It accepts the train when the short periods stand in the right ratio to the long ones. Because only the ratio counts, the accuracy of the slow oscillator does not matter.

Once it accepts a train, the block turns the port on. It waits a fixed number of fast-clock cycles, then pulls the line low for a fixed number of cycles. The host uses this low pulse to measure the fast clock. While the port is on, a host that holds the line low for too long resets the link. The block answers with a one-cycle strobe that forces the bit decoder back to the slow format, and then sends the same pulse again. Application software can claim the pin as general I/O before any wake-up train arrives. A system reset gives the pin back to the idle state. A reset command from the host, when enabled, turns the port back off. Bit-level decoding and command parsing live elsewhere.

Top module: `dbgwire_entry_seq`

## Requirements
- R1: After power-on reset (`rst_n` low), `mode` is 0 (idle), `drive_low` is 0 and `speed_reset` is 0. The mode codes are 0 = idle, 1 = I/O, 2 = active.
- R2: In idle mode the synchronised line is sampled only when `slow_tick` is high. A period is the number of ticks between two consecutive rising edges. The first rising edge seen opens the search. The next four periods form group A and the four after that form group B. When each group B period p satisfies 3/8·avg ≤ p ≤ 5/8·avg, where avg is the mean of the four group A periods, `mode` becomes 2 on the rising edge that closes the last group B period.
- R3: Both ends of the window in R2 are inclusive. A group B period outside the window leaves `mode` at 0 and drops the search, and the next rising edge opens a new one.
- R4: Acceptance depends only on the ratio. The same train scaled to longer or shorter periods is accepted in the same way.
- R5: `io_req` in idle mode moves `mode` to 1. In I/O mode the line is ignored and no train changes the mode.
- R6: `io_req` has no effect while `mode` is 2.
- R7: `sys_rst` moves mode 1 to mode 0. In idle and active modes it has no effect, and a train sent while `sys_rst` is held is still accepted.
- R8: On entry, `drive_low` rises exactly SYNC_DELAY (64) cycles after `mode` becomes 2 and stays high for exactly SYNC_LEN (128) cycles. It is never high outside mode 2.
- R9: In mode 2, outside a synchronisation pulse, a synchronised line that stays low for more than LOW_LIMIT (64) consecutive cycles produces exactly one single-cycle `speed_reset` pulse. A low run of 64 cycles or fewer produces none.
- R10: After a line reset, once the line is back high, `drive_low` rises SYNC_DELAY+3 cycles after the host releases `line_in` and stays high for SYNC_LEN cycles.
- R11: `srst_cmd` with `rst_ctl` = 1 in mode 2 sets `mode` to 0. With `rst_ctl` = 0 it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| line_in | input | 1 | Raw debug line level (asynchronous) |
| slow_tick | input | 1 | One-cycle strobe at the slow sampling rate |
| io_req | input | 1 | Software request to use the pin as general I/O |
| sys_rst | input | 1 | System reset indication |
| srst_cmd | input | 1 | Decoded host reset command strobe |
| rst_ctl | input | 1 | Allows a reset command to turn the port off |
| drive_low | output | 1 | Pull the line low (open-drain) |
| mode | output | 2 | 0 idle, 1 I/O, 2 active |
| speed_reset | output | 1 | One-cycle strobe forcing low-speed bit format |

## Verification
The assertions assume that `srst_cmd` and `rst_ctl` come from a single decoder: when both are high in active mode, that one cycle takes priority over `io_req` and over a line-reset hit. The frame-length property assumes the only path back to idle during a pulse is that reset command, so `drive_low` never restarts while still high. The stimulus drives the line only at negative edges, in whole multiples of the tick spacing, so every measured period is an exact tick count. It models the open-drain wire as the host level ANDed with the inverse of `drive_low`. Random trials apply a power-on reset between trains so that no half-finished search carries over.

// File: rtl/dbgwire_pkg.sv
package dbgwire_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_IO     = 2'd1,
    MODE_ACTIVE = 2'd2
  } mode_e;

  // Window test for a short-group period against the long-group sum:
  // 3/8 * (sum/4) <= p <= 5/8 * (sum/4)  <=>  3*sum <= 32*p <= 5*sum
  function automatic logic ratio_ok(input logic [31:0] p, input logic [31:0] sum_a);
    logic [39:0] lhs;
    logic [39:0] lo;
    logic [39:0] hi;
    lhs = 40'(p) << 5;
    lo  = 40'(sum_a) * 40'd3;
    hi  = 40'(sum_a) * 40'd5;
    return (lhs >= lo) && (lhs <= hi);
  endfunction

endpackage

// File: rtl/dbgwire_sync2.sv
module dbgwire_sync2 #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= {STAGES{RST_VAL}};
    else        ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/dbgwire_entry_det.sv
module dbgwire_entry_det
  import dbgwire_pkg::*;
#(
  parameter int PER_W = 16,
  parameter int GROUP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tick,
  input  logic line_s,
  output logic found
);
  localparam int MW    = PER_W + 1;
  localparam int SUM_W = MW + $clog2(GROUP);
  localparam int IDX_W = $clog2(2 * GROUP);
  localparam logic [PER_W-1:0] PER_MAX = {PER_W{1'b1}};

  logic             prev;
  logic             armed;
  logic [IDX_W-1:0] idx;
  logic [PER_W-1:0] per_cnt;
  logic [SUM_W-1:0] sum_a;

  logic          rise;
  logic [MW-1:0] meas;
  logic          in_b;
  logic          last;
  logic          b_ok;

  assign rise  = tick & line_s & ~prev;
  assign meas  = MW'(per_cnt) + 1'b1;
  assign in_b  = (idx >= IDX_W'(GROUP));
  assign last  = (idx == IDX_W'(2 * GROUP - 1));
  assign b_ok  = ratio_ok(32'(meas), 32'(sum_a));
  assign found = enable & armed & rise & in_b & last & b_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev    <= 1'b1;
      armed   <= 1'b0;
      idx     <= '0;
      per_cnt <= '0;
      sum_a   <= '0;
    end else begin
      if (tick) prev <= line_s;
      if (!enable) begin
        armed   <= 1'b0;
        idx     <= '0;
        per_cnt <= '0;
        sum_a   <= '0;
      end else if (tick) begin
        if (!armed) begin
          if (rise) begin
            armed   <= 1'b1;
            idx     <= '0;
            per_cnt <= '0;
            sum_a   <= '0;
          end
        end else if (rise) begin
          per_cnt <= '0;
          if (!in_b) begin
            sum_a <= sum_a + SUM_W'(meas);
            idx   <= idx + 1'b1;
          end else if (!b_ok || last) begin
            armed <= 1'b0;
          end else begin
            idx <= idx + 1'b1;
          end
        end else if (per_cnt == PER_MAX) begin
          armed <= 1'b0;
        end else begin
          per_cnt <= per_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dbgwire_lowrst_det.sv
module dbgwire_lowrst_det #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic line_s,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 2);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (!enable || line_s)  cnt <= '0;
    else if (cnt != CW'(LIMIT + 1)) cnt <= cnt + 1'b1;
  end

  assign hit = enable & ~line_s & (cnt == CW'(LIMIT));
endmodule

// File: rtl/dbgwire_sync_gen.sv
module dbgwire_sync_gen #(
  parameter int DELAY = 64,
  parameter int LEN   = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic drive,
  output logic busy
);
  localparam int MAXV = (DELAY > LEN) ? DELAY : LEN;
  localparam int CW   = $clog2(MAXV + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_FRAME} phase_e;

  phase_e        phase;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (abort) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (start) begin
      phase <= PH_WAIT;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_WAIT: begin
          if (cnt == CW'(DELAY - 1)) begin
            phase <= PH_FRAME;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_FRAME: begin
          if (cnt == CW'(LEN - 1)) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: cnt <= '0;
      endcase
    end
  end

  assign drive = (phase == PH_FRAME);
  assign busy  = (phase != PH_IDLE);
endmodule

// File: rtl/dbgwire_entry_seq.sv
module dbgwire_entry_seq
  import dbgwire_pkg::*;
#(
  parameter int PER_W       = 16,
  parameter int GROUP       = 4,
  parameter int SYNC_DELAY  = 64,
  parameter int SYNC_LEN    = 128,
  parameter int LOW_LIMIT   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_in,
  input  logic       slow_tick,
  input  logic       io_req,
  input  logic       sys_rst,
  input  logic       srst_cmd,
  input  logic       rst_ctl,
  output logic       drive_low,
  output logic [1:0] mode,
  output logic       speed_reset
);
  mode_e mode_q;
  logic  line_s;
  logic  lr_wait;
  logic  entry_ok;
  logic  lr_hit;
  logic  sync_busy;
  logic  sync_start;
  logic  leave_cmd;
  logic  in_off;
  logic  in_act;
  logic  lr_enable;

  assign in_off     = (mode_q == MODE_OFF);
  assign in_act     = (mode_q == MODE_ACTIVE);
  assign leave_cmd  = in_act & srst_cmd & rst_ctl;
  assign sync_start = (in_off & entry_ok) | (in_act & lr_wait & line_s & ~leave_cmd);
  assign lr_enable  = in_act & ~lr_wait & ~sync_busy;

  dbgwire_sync2 #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
  );

  dbgwire_entry_det #(.PER_W(PER_W), .GROUP(GROUP)) u_entry (
    .clk(clk), .rst_n(rst_n), .enable(in_off), .tick(slow_tick),
    .line_s(line_s), .found(entry_ok)
  );

  dbgwire_lowrst_det #(.LIMIT(LOW_LIMIT)) u_lowrst (
    .clk(clk), .rst_n(rst_n), .enable(lr_enable), .line_s(line_s), .hit(lr_hit)
  );

  dbgwire_sync_gen #(.DELAY(SYNC_DELAY), .LEN(SYNC_LEN)) u_syncgen (
    .clk(clk), .rst_n(rst_n), .start(sync_start), .abort(leave_cmd),
    .drive(drive_low), .busy(sync_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= MODE_OFF;
      lr_wait     <= 1'b0;
      speed_reset <= 1'b0;
    end else begin
      speed_reset <= lr_hit & ~leave_cmd;
      case (mode_q)
        MODE_OFF: begin
          if (entry_ok)    mode_q <= MODE_ACTIVE;
          else if (io_req) mode_q <= MODE_IO;
        end
        MODE_IO: begin
          if (sys_rst) mode_q <= MODE_OFF;
        end
        MODE_ACTIVE: begin
          if (leave_cmd) begin
            mode_q  <= MODE_OFF;
            lr_wait <= 1'b0;
          end else if (lr_hit) begin
            lr_wait <= 1'b1;
          end else if (sync_start) begin
            lr_wait <= 1'b0;
          end
        end
        default: mode_q <= MODE_OFF;
      endcase
    end
  end

  assign mode = mode_q;
endmodule

// File: rtl/dbgwire_entry_seq_chk.sv
module dbgwire_entry_seq_chk #(
  parameter int SYNC_LEN = 128
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       io_req,
  input logic       sys_rst,
  input logic       srst_cmd,
  input logic       rst_ctl,
  input logic       drive_low,
  input logic       speed_reset,
  input logic       entry_ok,
  input logic       lr_hit
);
  localparam int RW = $clog2(SYNC_LEN + 2);

  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run <= '0;
    else if (drive_low) run <= run + 1'b1;
    else                run <= '0;
  end

  a_r8_frame_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    drive_low |-> (run < RW'(SYNC_LEN)));

  a_r8_drive_only_active: assert property (@(posedge clk) disable iff (!rst_n)
    drive_low |-> (mode == 2'd2));

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    speed_reset |=> !speed_reset);

  a_r9_hit_gives_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_hit && !(srst_cmd && rst_ctl)) |=> speed_reset);

  a_r2_entry_activates: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && entry_ok) |=> (mode == 2'd2));

  a_r5_io_from_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && io_req && !entry_ok) |=> (mode == 2'd1));

  a_r6_io_ignored_active: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && io_req && !(srst_cmd && rst_ctl)) |=> (mode == 2'd2));

  a_r7_io_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && sys_rst) |=> (mode == 2'd0));

  a_r11_cmd_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && srst_cmd && rst_ctl) |=> (mode == 2'd0));
endmodule

bind dbgwire_entry_seq dbgwire_entry_seq_chk #(.SYNC_LEN(SYNC_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .io_req(io_req), .sys_rst(sys_rst),
  .srst_cmd(srst_cmd), .rst_ctl(rst_ctl), .drive_low(drive_low),
  .speed_reset(speed_reset), .entry_ok(entry_ok), .lr_hit(lr_hit)
);

// File: tb/dbgwire_entry_seq_bench.sv
module dbgwire_entry_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int DELAY      = 64;
  localparam int LEN        = 128;
  localparam int WD_LIMIT   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_line = 1'b1;
  logic       slow_tick = 1'b0;
  logic       io_req = 1'b0;
  logic       sys_rst = 1'b0;
  logic       srst_cmd = 1'b0;
  logic       rst_ctl = 1'b0;
  logic       drive_low;
  logic [1:0] mode;
  logic       speed_reset;
  logic       line_in;
  logic [1:0] tick_cnt = 2'd0;

  int n_chk = 0;
  int n_fail = 0;
  int sr_count = 0;
  int cyc = 0;
  int pa[4];
  int pb[4];

  assign line_in = host_line & ~drive_low;

  dbgwire_entry_seq u_dbgwire_entry_seq (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .slow_tick(slow_tick),
    .io_req(io_req), .sys_rst(sys_rst), .srst_cmd(srst_cmd), .rst_ctl(rst_ctl),
    .drive_low(drive_low), .mode(mode), .speed_reset(speed_reset)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    tick_cnt  <= tick_cnt + 2'd1;
    slow_tick <= (tick_cnt == 2'(TICK_DIV - 1));
  end

  always @(negedge clk) if (speed_reset) sr_count++;

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      n_fail++;
      $display("FAIL watchdog (R1..all): actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    cycles(n * TICK_DIV);
  endtask

  task automatic por();
    @(negedge clk);
    rst_n = 1'b0;
    host_line = 1'b1;
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
  endtask

  task automatic send_period(input int p);
    host_line = 1'b1;
    ticks(p - p / 2);
    host_line = 1'b0;
    ticks(p / 2);
    host_line = 1'b1;
  endtask

  task automatic send_seq();
    host_line = 1'b0;
    ticks(3);
    host_line = 1'b1;
    for (int i = 0; i < 4; i++) send_period(pa[i]);
    for (int i = 0; i < 4; i++) send_period(pb[i]);
  endtask

  function automatic int expect_accept();
    real avg;
    avg = real'(pa[0] + pa[1] + pa[2] + pa[3]) / 4.0;
    for (int i = 0; i < 4; i++)
      if (real'(pb[i]) < 0.375 * avg || real'(pb[i]) > 0.625 * avg) return 0;
    return 1;
  endfunction

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic host_low(input int n);
    host_line = 1'b0;
    cycles(n);
    host_line = 1'b1;
  endtask

  task automatic measure_frame(input string tag, input int exp_gap, input int offset);
    int cnt;
    int len;
    cnt = offset;
    while (!drive_low) begin
      @(negedge clk);
      cnt++;
    end
    check({tag, " delay"}, cnt, exp_gap);
    len = 0;
    while (drive_low) begin
      len++;
      @(negedge clk);
    end
    check({tag, " length"}, len, LEN);
  endtask

  task automatic trial(input string tag);
    int exp;
    por();
    exp = expect_accept();
    send_seq();
    ticks(4);
    check(tag, int'(mode), exp ? 2 : 0);
  endtask

  initial begin
    int seed;
    int cnt;
    seed = $urandom(32'd20240611);

    // R1 reset state
    @(negedge clk);
    check("R1 mode in reset", int'(mode), 0);
    check("R1 drive_low in reset", int'(drive_low), 0);
    por();
    check("R1 mode after reset", int'(mode), 0);
    check("R1 drive_low after reset", int'(drive_low), 0);
    check("R1 speed_reset after reset", int'(speed_reset), 0);

    // R2 / R8 nominal entry and synchronisation pulse
    pa = '{16, 16, 16, 16};
    pb = '{8, 8, 8, 8};
    send_seq();
    cnt = 0;
    while (mode != 2'd2 && cnt < 200) begin
      @(negedge clk);
      cnt++;
    end
    check("R2 nominal entry", int'(mode), 2);
    measure_frame("R8 entry frame", DELAY, 0);

    // R9 line reset threshold
    cycles(20);
    host_low(64);
    cycles(10);
    check("R9 64-cycle low gives no strobe", sr_count, 0);
    host_low(65);
    cycles(10);
    check("R9 65-cycle low gives one strobe", sr_count, 1);
    cycles(300);
    // R10 resync after line reset
    host_line = 1'b0;
    cycles(70);
    host_line = 1'b1;
    measure_frame("R10 resync frame", DELAY + 3, 0);
    check("R9 strobe count after second reset", sr_count, 2);
    check("R10 still active", int'(mode), 2);

    // R6 / R7 / R11 in active mode
    cycles(10);
    pulse(io_req);
    cycles(5);
    check("R6 io_req ignored when active", int'(mode), 2);
    pulse(sys_rst);
    cycles(5);
    check("R7 sys_rst ignored when active", int'(mode), 2);
    rst_ctl = 1'b0;
    pulse(srst_cmd);
    cycles(5);
    check("R11 command without rst_ctl", int'(mode), 2);
    rst_ctl = 1'b1;
    pulse(srst_cmd);
    rst_ctl = 1'b0;
    cycles(2);
    check("R11 command with rst_ctl", int'(mode), 0);
    check("R8 no drive after exit", int'(drive_low), 0);

    // R3 mismatch then restart with a good train
    por();
    pa = '{16, 16, 16, 16};
    pb = '{8, 8, 8, 11};
    send_seq();
    ticks(4);
    check("R3 out-of-window rejected", int'(mode), 0);
    pb = '{8, 8, 8, 8};
    send_seq();
    ticks(4);
    check("R3 search restarts", int'(mode), 2);

    // R3 inclusive edges and just-outside values
    pa = '{16, 16, 16, 16};
    pb = '{6, 10, 6, 10};
    trial("R3 window edges accepted");
    pb = '{5, 8, 8, 8};
    trial("R3 below lower edge rejected");
    pb = '{8, 8, 8, 11};
    trial("R3 above upper edge rejected");

    // R4 scaling
    pa = '{40, 40, 40, 40};
    pb = '{20, 20, 20, 20};
    trial("R4 slow scale");
    pa = '{10, 10, 10, 10};
    pb = '{5, 5, 5, 5};
    trial("R4 fast scale");
    pa = '{12, 20, 16, 16};
    pb = '{9, 7, 8, 8};
    trial("R4 uneven long group");

    // R5 / R7 I/O mode
    por();
    pulse(io_req);
    cycles(2);
    check("R5 io_req in idle", int'(mode), 1);
    pa = '{16, 16, 16, 16};
    pb = '{8, 8, 8, 8};
    send_seq();
    ticks(4);
    check("R5 train ignored in I/O", int'(mode), 1);
    pulse(sys_rst);
    cycles(2);
    check("R7 sys_rst leaves I/O", int'(mode), 0);

    // R7 train accepted while system reset is held
    por();
    sys_rst = 1'b1;
    send_seq();
    ticks(4);
    sys_rst = 1'b0;
    check("R7 entry during sys_rst", int'(mode), 2);

    // R2 / R3 random trains
    for (int t = 0; t < 14; t++) begin
      for (int i = 0; i < 4; i++) pa[i] = 10 + int'($urandom % 21);
      for (int i = 0; i < 4; i++) begin
        if ($urandom % 2 == 0)
          pb[i] = (pa[0] + pa[1] + pa[2] + pa[3]) / 8 + int'($urandom % 5) - 2;
        else
          pb[i] = 2 + int'($urandom % 20);
        if (pb[i] < 2) pb[i] = 2;
      end
      trial("R2 random train");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule